// File: doc/BRIEF.md
# Memory Region Conflict Scoreboard

This block lets a processor and several decoupled coprocessor units run at the same time while still producing the results of a strictly sequential program. Every coprocessor operation reads one source memory region and writes one destination region. Each region is given as a base address and a log2 size, is a power of two in size and is aligned to that size. When an operation is issued, the scoreboard stores its two regions in a free entry. When the operation finishes, the completion port names that entry and the entry is released. Coprocessor operations keep no state between runs, so nothing else is retained after completion.

Every cycle, the block compares the presented processor access and the presented coprocessor issue with all live entries. A processor load stalls when it touches a region that an in-flight operation will write. A processor store stalls when it touches any region an in-flight operation reads or writes. A new issue is held back on read-after-write, write-after-read or write-after-write overlap with any live operation, and it is also held back when every entry is in use.

The issue port is a valid/ready handshake. An issue transfers on a cycle where both `iss_valid` and `iss_ready` are high. The source must keep the request stable until it transfers. `iss_ready` is combinational in the presented payload and the current entry state. The stall output and the conflict flag are plain combinational status.

Top module: `mem_region_scoreboard`

## Requirements
- R1: After reset no entry is live. No processor access stalls, and `iss_ready` is high.
- R2: An issue transfers when `iss_valid` and `iss_ready` are both high. It takes the lowest-numbered free entry, and that entry's index is on `iss_idx` in the same cycle.
- R3: A region covers the 2^lg bytes whose address bits at positions lg and above equal those of its base. A processor access is a single byte (lg 0). Two regions overlap exactly when their address bits at and above the larger of their two lg values are equal; an lg of at least the address width covers the whole space.
- R4: A processor load (`pa_is_store` = 0) stalls only if its address lies in the destination region of a live entry. A hit on a source region alone does not stall a load.
- R5: A processor store (`pa_is_store` = 1) stalls if its address lies in the source or the destination region of any live entry.
- R6: An issue whose destination overlaps the source or the destination of any live entry raises `iss_conflict`, and `iss_ready` is low.
- R7: An issue whose source overlaps the destination of any live entry raises `iss_conflict`, and `iss_ready` is low. Overlap between its source and a live source is allowed.
- R8: When all ENTRIES entries are live, `iss_ready` is low. `iss_conflict` then reflects only overlap.
- R9: A completion clears the entry named by `cmp_idx` at the clock edge. Checks in the completion cycle still see the entry, and checks in the next cycle do not.
- R10: A completion that names an entry that is not live has no effect, even when an issue fills that entry in the same cycle.
- R11: An entry released in a given cycle is not handed to an issue in that same cycle. Allocation uses the state from before the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request present |
| iss_ready | output | 1 | Issue can transfer this cycle |
| iss_src_base | input | ADDR_W | Source region base |
| iss_src_lg | input | LG_W | Source region log2 size |
| iss_dst_base | input | ADDR_W | Destination region base |
| iss_dst_lg | input | LG_W | Destination region log2 size |
| iss_idx | output | IDX_W | Entry allocated to the issue |
| iss_conflict | output | 1 | Presented issue overlaps a live entry |
| cmp_valid | input | 1 | Completion present |
| cmp_idx | input | IDX_W | Entry being completed |
| pa_valid | input | 1 | Processor access present |
| pa_is_store | input | 1 | 1 = store, 0 = load |
| pa_addr | input | ADDR_W | Processor byte address |
| pa_stall | output | 1 | Processor access must wait |

## Verification
The bench builds the block with ENTRIES = 4 and ADDR_W = 16, so LG_W is 5. Four transferred issues are then enough to fill the table, which lets the full-refusal case and reuse after release be reached in a short sequence. The 16-bit space also makes it cheap to present a large region (lg 14) that overlaps several small live regions at once. Same-cycle completion and issue are driven on both a live and a free entry.

// File: rtl/sb_pkg.sv
package sb_pkg;
  // bit positions of the per-entry hit vector
  localparam int HIT_PA_DST = 0;  // processor access vs entry destination
  localparam int HIT_PA_SRC = 1;  // processor access vs entry source
  localparam int HIT_RAW    = 2;  // new source vs entry destination
  localparam int HIT_WAR    = 3;  // new destination vs entry source
  localparam int HIT_WAW    = 4;  // new destination vs entry destination
  localparam int HIT_N      = 5;
endpackage

// File: rtl/sb_region_match.sv
module sb_region_match #(
  parameter int ADDR_W = 32,
  parameter int LG_W   = 6
) (
  input  logic [ADDR_W-1:0] a_base,
  input  logic [LG_W-1:0]   a_lg,
  input  logic [ADDR_W-1:0] b_base,
  input  logic [LG_W-1:0]   b_lg,
  output logic              hit
);
  logic [LG_W-1:0]   big_lg;
  logic [ADDR_W-1:0] keep;

  always_comb begin
    big_lg = (a_lg > b_lg) ? a_lg : b_lg;
    if (int'(big_lg) >= ADDR_W) keep = '0;
    else                        keep = {ADDR_W{1'b1}} << big_lg;
    hit = (((a_base ^ b_base) & keep) == '0);
  end
endmodule

// File: rtl/sb_alloc.sv
module sb_alloc #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] live,
  output logic [IDX_W-1:0]   free_idx,
  output logic               any_free
);
  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!live[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sb_entry_file.sv
module sb_entry_file #(
  parameter int ADDR_W  = 32,
  parameter int LG_W    = 6,
  parameter int ENTRIES = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           alloc_en,
  input  logic [IDX_W-1:0]               alloc_idx,
  input  logic [ADDR_W-1:0]              alloc_src_base,
  input  logic [LG_W-1:0]                alloc_src_lg,
  input  logic [ADDR_W-1:0]              alloc_dst_base,
  input  logic [LG_W-1:0]                alloc_dst_lg,
  input  logic                           free_en,
  input  logic [IDX_W-1:0]               free_idx,
  output logic [ENTRIES-1:0]             live_q,
  output logic [ENTRIES-1:0][ADDR_W-1:0] src_base_q,
  output logic [ENTRIES-1:0][LG_W-1:0]   src_lg_q,
  output logic [ENTRIES-1:0][ADDR_W-1:0] dst_base_q,
  output logic [ENTRIES-1:0][LG_W-1:0]   dst_lg_q
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    wire sel_alloc = alloc_en && (alloc_idx == IDX_W'(g));
    wire sel_free  = free_en  && (free_idx  == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live_q[g]     <= 1'b0;
        src_base_q[g] <= '0;
        src_lg_q[g]   <= '0;
        dst_base_q[g] <= '0;
        dst_lg_q[g]   <= '0;
      end else if (sel_alloc) begin
        // allocation only targets a free entry, so it wins over a stray free
        live_q[g]     <= 1'b1;
        src_base_q[g] <= alloc_src_base;
        src_lg_q[g]   <= alloc_src_lg;
        dst_base_q[g] <= alloc_dst_base;
        dst_lg_q[g]   <= alloc_dst_lg;
      end else if (sel_free) begin
        live_q[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mem_region_scoreboard.sv
module mem_region_scoreboard #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 4,
  localparam int LG_W   = $clog2(ADDR_W + 1),
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic [ADDR_W-1:0] iss_src_base,
  input  logic [LG_W-1:0]   iss_src_lg,
  input  logic [ADDR_W-1:0] iss_dst_base,
  input  logic [LG_W-1:0]   iss_dst_lg,
  output logic [IDX_W-1:0]  iss_idx,
  output logic              iss_conflict,
  input  logic              cmp_valid,
  input  logic [IDX_W-1:0]  cmp_idx,
  input  logic              pa_valid,
  input  logic              pa_is_store,
  input  logic [ADDR_W-1:0] pa_addr,
  output logic              pa_stall
);
  import sb_pkg::*;

  logic [ENTRIES-1:0]             live_q;
  logic [ENTRIES-1:0][ADDR_W-1:0] src_base_q;
  logic [ENTRIES-1:0][LG_W-1:0]   src_lg_q;
  logic [ENTRIES-1:0][ADDR_W-1:0] dst_base_q;
  logic [ENTRIES-1:0][LG_W-1:0]   dst_lg_q;
  logic [ENTRIES-1:0][HIT_N-1:0]  hit;
  logic [HIT_N-1:0]               any_hit;
  logic [IDX_W-1:0]               free_idx;
  logic                           any_free;
  logic                           accept;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [HIT_N-1:0] raw_hit;

    sb_region_match #(.ADDR_W(ADDR_W), .LG_W(LG_W)) u_pa_dst (
      .a_base(pa_addr), .a_lg('0),
      .b_base(dst_base_q[g]), .b_lg(dst_lg_q[g]), .hit(raw_hit[HIT_PA_DST]));
    sb_region_match #(.ADDR_W(ADDR_W), .LG_W(LG_W)) u_pa_src (
      .a_base(pa_addr), .a_lg('0),
      .b_base(src_base_q[g]), .b_lg(src_lg_q[g]), .hit(raw_hit[HIT_PA_SRC]));
    sb_region_match #(.ADDR_W(ADDR_W), .LG_W(LG_W)) u_raw (
      .a_base(iss_src_base), .a_lg(iss_src_lg),
      .b_base(dst_base_q[g]), .b_lg(dst_lg_q[g]), .hit(raw_hit[HIT_RAW]));
    sb_region_match #(.ADDR_W(ADDR_W), .LG_W(LG_W)) u_war (
      .a_base(iss_dst_base), .a_lg(iss_dst_lg),
      .b_base(src_base_q[g]), .b_lg(src_lg_q[g]), .hit(raw_hit[HIT_WAR]));
    sb_region_match #(.ADDR_W(ADDR_W), .LG_W(LG_W)) u_waw (
      .a_base(iss_dst_base), .a_lg(iss_dst_lg),
      .b_base(dst_base_q[g]), .b_lg(dst_lg_q[g]), .hit(raw_hit[HIT_WAW]));

    assign hit[g] = live_q[g] ? raw_hit : '0;
  end

  always_comb begin
    any_hit = '0;
    for (int i = 0; i < ENTRIES; i++) any_hit |= hit[i];
  end

  sb_alloc #(.ENTRIES(ENTRIES)) u_alloc (
    .live(live_q), .free_idx(free_idx), .any_free(any_free));

  always_comb begin
    pa_stall     = pa_valid && (any_hit[HIT_PA_DST] ||
                                (pa_is_store && any_hit[HIT_PA_SRC]));
    iss_conflict = iss_valid && (any_hit[HIT_RAW] || any_hit[HIT_WAR] ||
                                 any_hit[HIT_WAW]);
    iss_ready    = any_free && !iss_conflict;
    iss_idx      = free_idx;
    accept       = iss_valid && iss_ready;
  end

  sb_entry_file #(.ADDR_W(ADDR_W), .LG_W(LG_W), .ENTRIES(ENTRIES)) u_file (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(accept), .alloc_idx(free_idx),
    .alloc_src_base(iss_src_base), .alloc_src_lg(iss_src_lg),
    .alloc_dst_base(iss_dst_base), .alloc_dst_lg(iss_dst_lg),
    .free_en(cmp_valid), .free_idx(cmp_idx),
    .live_q(live_q), .src_base_q(src_base_q), .src_lg_q(src_lg_q),
    .dst_base_q(dst_base_q), .dst_lg_q(dst_lg_q));
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int ENTRIES = 4,
  parameter int IDX_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               iss_valid,
  input logic               iss_ready,
  input logic [IDX_W-1:0]   iss_idx,
  input logic               cmp_valid,
  input logic [IDX_W-1:0]   cmp_idx,
  input logic               pa_stall,
  input logic [ENTRIES-1:0] live
);
  AST_ALLOC_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |=> live[$past(iss_idx)]); // R2
  AST_ALLOC_WAS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |-> !live[iss_idx]); // R11
  AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (&live) |-> !iss_ready); // R8
  AST_STALL_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    pa_stall |-> (|live)); // R4
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && live[cmp_idx]) |=> !live[$past(cmp_idx)]); // R9
  AST_COUNT_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid || cmp_valid) |=> ($countones(live) ==
      $past($countones(live)) + int'($past(iss_valid && iss_ready))
      - int'($past(cmp_valid && live[cmp_idx])))); // R10
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(iss_valid || cmp_valid) |=> $stable(live)); // R9
endmodule

bind mem_region_scoreboard sb_checker #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
  .iss_idx(iss_idx), .cmp_valid(cmp_valid), .cmp_idx(cmp_idx),
  .pa_stall(pa_stall), .live(live_q));

// File: tb/mem_region_scoreboard_tb_top.sv
module mem_region_scoreboard_tb_top;
  localparam int AW = 16;
  localparam int NE = 4;
  localparam int LW = $clog2(AW + 1);
  localparam int IW = $clog2(NE);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_valid = 0, iss_ready, iss_conflict;
  logic [AW-1:0] iss_src_base = '0, iss_dst_base = '0;
  logic [LW-1:0] iss_src_lg = '0, iss_dst_lg = '0;
  logic [IW-1:0] iss_idx;
  logic cmp_valid = 0;
  logic [IW-1:0] cmp_idx = '0;
  logic pa_valid = 0, pa_is_store = 0, pa_stall;
  logic [AW-1:0] pa_addr = '0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    string         tag;
    logic          stall;
    logic          rdy;
    logic          conf;
    bit            chk_idx;
    logic [IW-1:0] idx;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  mem_region_scoreboard #(.ADDR_W(AW), .ENTRIES(NE)) dut_i (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_src_base(iss_src_base), .iss_src_lg(iss_src_lg),
    .iss_dst_base(iss_dst_base), .iss_dst_lg(iss_dst_lg),
    .iss_idx(iss_idx), .iss_conflict(iss_conflict),
    .cmp_valid(cmp_valid), .cmp_idx(cmp_idx),
    .pa_valid(pa_valid), .pa_is_store(pa_is_store), .pa_addr(pa_addr),
    .pa_stall(pa_stall));

  task automatic cmp1(string tag, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // monitor: compares one expected item per cycle, 1 ns after the falling edge
  always begin
    @(negedge clk);
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      cmp1(e.tag, "pa_stall", pa_stall, e.stall);
      cmp1(e.tag, "iss_ready", iss_ready, e.rdy);
      cmp1(e.tag, "iss_conflict", iss_conflict, e.conf);
      if (e.chk_idx) begin
        total++;
        if (iss_idx !== e.idx) begin
          bad++;
          $display("FAIL %s iss_idx actual=%0d expected=%0d", e.tag, iss_idx, e.idx);
        end
      end
    end
  end

  // driver: presents one cycle of stimulus and queues what must be seen
  task automatic step(string tag,
                      logic pv, logic pst, logic [AW-1:0] pa,
                      logic iv, logic [AW-1:0] sb, logic [LW-1:0] sl,
                      logic [AW-1:0] db, logic [LW-1:0] dl,
                      logic cv, logic [IW-1:0] ci,
                      logic e_stall, logic e_rdy, logic e_conf,
                      bit e_chk, logic [IW-1:0] e_idx);
    exp_t e;
    @(negedge clk);
    pa_valid = pv; pa_is_store = pst; pa_addr = pa;
    iss_valid = iv; iss_src_base = sb; iss_src_lg = sl;
    iss_dst_base = db; iss_dst_lg = dl;
    cmp_valid = cv; cmp_idx = ci;
    e.tag = tag; e.stall = e_stall; e.rdy = e_rdy; e.conf = e_conf;
    e.chk_idx = e_chk; e.idx = e_idx;
    exp_q.push_back(e);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1: empty table
    step("R1", 1,1,16'h0000, 0,0,0,0,0, 0,0, 0,1,0, 0,0);
    // R2: op A src 1000/8 dst 2000/8 -> entry 0
    step("R2", 0,0,0, 1,16'h1000,8,16'h2000,8, 0,0, 0,1,0, 1,0);
    step("R4 load hits dst", 1,0,16'h2010, 0,0,0,0,0, 0,0, 1,1,0, 0,0);
    step("R4 load on src only", 1,0,16'h1010, 0,0,0,0,0, 0,0, 0,1,0, 0,0);
    step("R5 store hits src", 1,1,16'h1010, 0,0,0,0,0, 0,0, 1,1,0, 0,0);
    step("R5 store no hit", 1,1,16'h3000, 0,0,0,0,0, 0,0, 0,1,0, 0,0);
    step("R7 RAW refused", 0,0,0, 1,16'h2080,4,16'h4000,4, 0,0, 0,0,1, 0,0);
    // R7: shared source allowed, op B -> entry 1
    step("R7 src-src ok", 0,0,0, 1,16'h1000,4,16'h4000,4, 0,0, 0,1,0, 1,1);
    step("R6 WAR refused", 0,0,0, 1,16'h5000,4,16'h1008,2, 0,0, 0,0,1, 0,0);
    step("R3 large dst overlap", 0,0,0, 1,16'h5000,4,16'h0000,14, 0,0, 0,0,1, 0,0);
    step("R2 op C", 0,0,0, 1,16'h5000,4,16'h6000,4, 0,0, 0,1,0, 1,2);
    step("R2 op D", 0,0,0, 1,16'h5000,4,16'h7000,4, 0,0, 0,1,0, 1,3);
    step("R8 full", 0,0,0, 1,16'h8000,4,16'h9000,4, 0,0, 0,0,0, 0,0);
    // R9/R11: complete B while full; still seen this cycle, no reuse this cycle
    step("R9 same cycle", 1,1,16'h4004, 1,16'h8000,4,16'h9000,4, 1,1, 1,0,0, 0,0);
    step("R9 released", 1,1,16'h4004, 1,16'h8000,4,16'h9000,4, 0,0, 0,1,0, 1,1);
    step("R8 full again", 0,0,0, 0,0,0,0,0, 1,2, 0,0,0, 0,0);
    // R10: completion of free entry 2 while op F fills it
    step("R10 fill", 0,0,0, 1,16'hA000,4,16'hB000,4, 1,2, 0,1,0, 1,2);
    step("R10 kept", 1,0,16'hB004, 0,0,0,0,0, 0,0, 1,0,0, 0,0);
    step("R9 free D", 0,0,0, 0,0,0,0,0, 1,3, 0,0,0, 0,0);
    step("R11 no same-cycle reuse", 0,0,0, 1,16'hC000,4,16'hD000,4, 1,0, 0,1,0, 1,3);
    step("R9 A gone", 1,0,16'h2000, 0,0,0,0,0, 0,0, 0,1,0, 0,0);
    step("R2 reuse entry 0", 0,0,0, 1,16'h2000,8,16'h2100,8, 0,0, 0,1,0, 1,0);
    step("R5 store on new src", 1,1,16'h2000, 0,0,0,0,0, 0,0, 1,0,0, 0,0);
    step("R4 load on new src", 1,0,16'h2000, 0,0,0,0,0, 0,0, 0,0,0, 0,0);
    @(negedge clk);
    pa_valid = 0; iss_valid = 0; cmp_valid = 0;
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          total++;
          bad++;
          $display("FAIL R1 watchdog actual=hung expected=finished");
        end
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule